// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns a stream of stereo PCM sample pairs into a serial data line with a bit clock and a frame clock. A producer offers one left/right pair at a time with a valid/ready handshake. The transmitter takes one pair per frame and sends both channels inside that frame. Each frame is 64 bit-clock slots, 32 per channel half. Five framing variants are chosen at run time. They differ only in which slot carries each channel's most significant bit.

The bit clock and the frame clock each have their own polarity control. Each also has its own role select. When the block is master of the bit clock, it divides the system clock to make the bit clock. When it is slave, it synchronises an external bit clock and follows its edges. When it is master of the frame clock, it generates that clock from its own slot counter. When it is slave, it realigns the counter on each frame edge it receives. If the producer has no pair ready when a frame begins, the block sends a silent frame and raises a flag.

Top module: `serial_audio_tx`

## Requirements
- R1: Terms used below. The effective bit clock is the bit clock XOR `inv_bclk`. The effective frame clock is the frame clock XOR `inv_frame`. Data and the frame clock change only on falling edges of the effective bit clock. A slot is the period from one such falling edge to the next. Slot 0 is the slot in which the frame begins. Samples are right-aligned in `s_left`/`s_right` and are sent MSB first. With `fmt`=0, the frame clock is low for the left half (slots 0-31) and high for the right half (slots 32-63). The left MSB is in slot 1 and the right MSB is in slot 33.
- R2: With `fmt`=1, the framing is the same as R1 except that the MSBs are in slot 0 (left) and slot 32 (right).
- R3: With `fmt`=2, the framing is the same as R1 except that each channel's LSB is in the last slot of its half. The left MSB is in slot 32-W and the right MSB is in slot 64-W, where W is the sample width.
- R4: With `fmt`=3, the effective frame clock is a pulse one slot wide, high in slot 0 only. The left MSB is in slot 1. The right channel starts in the slot directly after the left LSB, slot 1+W. A right LSB that falls past slot 63 is sent in slot 0 of the next frame.
- R5: With `fmt`=4, the frame pulse is the same as R4. The left MSB is in slot 0 and the right MSB is in slot W.
- R6: `width_sel` values 0, 1, 2 and 3 select W = 16, 20, 24 and 32 bits. Input bits above W are ignored. Every slot that carries no sample bit is driven 0. With `fmt`=0 and W=32, the right LSB is sent in slot 0 of the next frame.
- R7: Setting `inv_bclk` inverts the bit clock sense, on the output pin and on the input pin. Setting `inv_frame` inverts the frame clock sense in the same way. Neither setting changes which slot carries which bit.
- R8: When `bclk_master`=1, `bclk_o` has a period of 2*HALF_DIV clock cycles and `bclk_oe` is 1. When `frame_master`=1, `lrc_oe` is 1. A master frame clock completes exactly one frame every 64 bit-clock periods.
- R9: When `bclk_master`=0, slots follow falling edges of the effective `bclk_in`. When `frame_master`=0, the frame restarts at slot 0 on each frame edge seen on `lrc_in`. That edge is a fall of the effective frame clock for `fmt` 0-2 and a rise for `fmt` 3-4. The two role selects are independent of each other.
- R10: `s_ready` is high while the single holding register is empty. A pair is accepted when `s_valid` and `s_ready` are both high, and `s_ready` goes low in the following cycle. Each frame sends the pair held at its start, so successive accepted pairs appear in successive frames.
- R11: If no pair is held when a frame begins, that frame sends only zeros and `underrun` is 1 for the whole frame. `underrun` returns to 0 at the start of the next frame that has a pair.
- R12: While reset is asserted, `sd_o` is 0, `underrun` is 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding register free |
| s_left | input | SLOT_W | Left sample, right-aligned |
| s_right | input | SLOT_W | Right sample, right-aligned |
| fmt | input | 3 | Framing variant, 0 to 4 |
| width_sel | input | 2 | Sample width code |
| inv_bclk | input | 1 | Invert bit clock sense |
| inv_frame | input | 1 | Invert frame clock sense |
| bclk_master | input | 1 | Generate the bit clock |
| frame_master | input | 1 | Generate the frame clock |
| bclk_in | input | 1 | External bit clock (slave) |
| lrc_in | input | 1 | External frame clock (slave) |
| bclk_o | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Bit clock output enable |
| lrc_o | output | 1 | Generated frame clock |
| lrc_oe | output | 1 | Frame clock output enable |
| sd_o | output | 1 | Serial data |
| underrun | output | 1 | Current frame had no sample pair |

## Verification
The assertions assume that the format, width, polarity and role inputs are held constant whenever reset is released. They also assume that an external bit clock stays high and low for several system clock cycles. The bench changes configuration only while reset is asserted. In slave mode it drives each phase of the external bit clock for eight system cycles. It changes the external frame clock only together with a falling edge of the external bit clock, as a well-behaved link master does.

// File: rtl/serial_audio_tx.sv
module serial_audio_tx #(
  parameter int HALF_DIV = 4,
  parameter int SLOT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [SLOT_W-1:0] s_left,
  input  logic [SLOT_W-1:0] s_right,
  input  logic [2:0]        fmt,
  input  logic [1:0]        width_sel,
  input  logic              inv_bclk,
  input  logic              inv_frame,
  input  logic              bclk_master,
  input  logic              frame_master,
  input  logic              bclk_in,
  input  logic              lrc_in,
  output logic              bclk_o,
  output logic              bclk_oe,
  output logic              lrc_o,
  output logic              lrc_oe,
  output logic              sd_o,
  output logic              underrun
);
  localparam int FRAME = 2 * SLOT_W;
  localparam int PW    = $clog2(FRAME);
  localparam int CW    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [2:0] F_LJ = 3'd1, F_RJ = 3'd2, F_DSPA = 3'd3, F_DSPB = 3'd4;

  logic [CW-1:0]     div_cnt;
  logic              bclk_int, lrc_q, bs_prev, lrc_prev, buf_full;
  logic [1:0]        bsync, lsync;
  logic [PW-1:0]     pos, np, wid, ld_l, ld_r, cnt, sh_amt;
  logic [SLOT_W-1:0] sh, buf_l, buf_r, cur_l, cur_r, src_l, src_r;
  logic              tick, fr_tick, is_dsp, bs_now, ls_now, ext_start, accept;

  assign is_dsp    = (fmt == F_DSPA) || (fmt == F_DSPB);
  assign bs_now    = bsync[1] ^ inv_bclk;
  assign ls_now    = lsync[1] ^ inv_frame;
  assign ext_start = is_dsp ? (!lrc_prev && ls_now) : (lrc_prev && !ls_now);
  assign tick      = bclk_master ? (bclk_int && div_cnt == CW'(HALF_DIV - 1))
                                 : (bs_prev && !bs_now);
  assign np        = (!frame_master && ext_start) ? '0 : pos + 1'b1;
  assign fr_tick   = tick && (np == '0);
  assign accept    = s_valid && s_ready;
  assign src_l     = fr_tick ? (buf_full ? buf_l : '0) : cur_l;
  assign src_r     = fr_tick ? (buf_full ? buf_r : '0) : cur_r;
  assign sh_amt    = PW'(SLOT_W) - wid;

  always_comb begin
    case (width_sel)
      2'd0:    wid = PW'(16);
      2'd1:    wid = PW'(20);
      2'd2:    wid = PW'(24);
      default: wid = PW'(SLOT_W);
    endcase
    case (fmt)
      F_LJ:   begin ld_l = '0;                  ld_r = PW'(SLOT_W);     end
      F_RJ:   begin ld_l = PW'(SLOT_W) - wid;   ld_r = PW'(FRAME) - wid; end
      F_DSPA: begin ld_l = PW'(1);              ld_r = PW'(1) + wid;    end
      F_DSPB: begin ld_l = '0;                  ld_r = wid;             end
      default: begin ld_l = PW'(1);             ld_r = PW'(SLOT_W + 1); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsync    <= '0;
      lsync    <= '0;
      bs_prev  <= 1'b0;
      lrc_prev <= ~is_dsp;
      div_cnt  <= '0;
      bclk_int <= 1'b0;
      lrc_q    <= ~is_dsp;
      pos      <= '1;
      cnt      <= '0;
      sh       <= '0;
      buf_l    <= '0;
      buf_r    <= '0;
      cur_l    <= '0;
      cur_r    <= '0;
      buf_full <= 1'b0;
      underrun <= 1'b0;
    end else begin
      bsync   <= {bsync[0], bclk_in};
      lsync   <= {lsync[0], lrc_in};
      bs_prev <= bs_now;
      if (!bclk_master) begin
        div_cnt  <= '0;
        bclk_int <= 1'b0;
      end else if (div_cnt == CW'(HALF_DIV - 1)) begin
        div_cnt  <= '0;
        bclk_int <= ~bclk_int;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
      if (accept) begin
        buf_l <= s_left;
        buf_r <= s_right;
      end
      buf_full <= accept ? 1'b1 : (fr_tick ? 1'b0 : buf_full);
      if (tick) begin
        pos      <= np;
        lrc_prev <= ls_now;
        lrc_q    <= is_dsp ? (np == '0) : np[PW-1];
        if (fr_tick) begin
          cur_l    <= src_l;
          cur_r    <= src_r;
          underrun <= !buf_full;
        end
        if (np == ld_l) begin
          sh  <= src_l << sh_amt;
          cnt <= wid;
        end else if (np == ld_r) begin
          sh  <= src_r << sh_amt;
          cnt <= wid;
        end else if (cnt != '0) begin
          sh  <= sh << 1;
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign s_ready = !buf_full;
  assign sd_o    = (cnt != '0) && sh[SLOT_W-1];
  assign bclk_o  = bclk_int ^ inv_bclk;
  assign lrc_o   = lrc_q ^ inv_frame;
  assign bclk_oe = bclk_master;
  assign lrc_oe  = frame_master;
endmodule

// File: rtl/serial_audio_tx_chk.sv
module serial_audio_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_master,
  input logic frame_master,
  input logic inv_bclk,
  input logic s_valid,
  input logic s_ready,
  input logic sd_o,
  input logic bclk_o,
  input logic lrc_o
);
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready); // R10

  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_master && !$stable(sd_o)) |-> $fell(bclk_o ^ inv_bclk)); // R1

  AST_LRC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_master && frame_master && !$stable(lrc_o)) |-> $fell(bclk_o ^ inv_bclk)); // R8

  AST_BCLK_QUIET_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_master |-> $stable(bclk_o)); // R9
endmodule

bind serial_audio_tx serial_audio_tx_chk u_chk (.*);

// File: tb/test_serial_audio_tx.sv
module test_serial_audio_tx;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, sv = 1'b0, ib = 1'b0, ifr = 1'b0, bm = 1'b1, fm = 1'b1;
  logic [31:0] sl = '0, sr = '0;
  logic [2:0] fmt = '0;
  logic [1:0] wsel = '0;
  logic bclk_in, lrc_in;
  logic s_ready, bclk_o, bclk_oe, lrc_o, lrc_oe, sd_o, underrun;

  serial_audio_tx i_serial_audio_tx (
    .clk(clk), .rst_n(rst_n), .s_valid(sv), .s_ready(s_ready), .s_left(sl), .s_right(sr),
    .fmt(fmt), .width_sel(wsel), .inv_bclk(ib), .inv_frame(ifr),
    .bclk_master(bm), .frame_master(fm), .bclk_in(bclk_in), .lrc_in(lrc_in),
    .bclk_o(bclk_o), .bclk_oe(bclk_oe), .lrc_o(lrc_o), .lrc_oe(lrc_oe),
    .sd_o(sd_o), .underrun(underrun));

  int n_chk = 0, n_bad = 0;
  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // fmt, wsel, inv_bclk, inv_frame, bclk_master, frame_master, left, right
  localparam logic [72:0] VEC [13] = '{
    {3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_A5C3, 32'h0000_3C96},
    {3'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_8001, 32'h0000_F00F},
    {3'd2, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_C001, 32'h0000_8003},
    {3'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_9A5B, 32'h0000_D1E3},
    {3'd4, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_B00D, 32'h0000_8421},
    {3'd0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 32'h8123_4567, 32'hC0FF_EE01},
    {3'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFFF8_1235, 32'hABC0_0001},
    {3'd3, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 32'h8765_4321, 32'h9000_0003},
    {3'd1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 32'h00C3_A5E1, 32'h0080_0001},
    {3'd4, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 32'h00F0_0F01, 32'h0081_2345},
    {3'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_E00B, 32'h0000_8117},
    {3'd3, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h000A_BCDE, 32'h0008_0013},
    {3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_CAFE, 32'h0000_9009}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0:         return "R1";
      1:         return "R2";
      2:         return "R3";
      3, 7:      return "R4";
      4:         return "R5";
      5:         return "R1 R6";
      6:         return "R3 R6";
      8, 9:      return "R7";
      default:   return "R9";
    endcase
  endfunction

  function automatic int wbits(input logic [1:0] c);
    case (c)
      2'd0: return 16;
      2'd1: return 20;
      2'd2: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input logic [2:0] f, input int w,
      input logic [31:0] l, input logic [31:0] r, input logic [31:0] pr);
    int a, b;
    logic [63:0] e;
    case (f)
      3'd1: begin a = 0; b = 32; end
      3'd2: begin a = 32 - w; b = 64 - w; end
      3'd3: begin a = 1; b = 1 + w; end
      3'd4: begin a = 0; b = w; end
      default: begin a = 1; b = 33; end
    endcase
    e = '0;
    for (int i = 0; i < w; i++) begin
      e[63 - (a + i)] = l[w - 1 - i];
      if (b + i < 64) e[63 - (b + i)] = r[w - 1 - i];
      else            e[63 - (b + i - 64)] = pr[w - 1 - i];
    end
    return e;
  endfunction

  // receiver model: samples data on rising edges of the effective bit clock
  logic [63:0] cap;
  logic [63:0] frames [16];
  logic        und [16];
  int nf = 0, j = 0, badlen = 0;
  bit jv = 0, eb_p = 1, el_p = 1, mon_en = 0, eb, el, st;

  always @(negedge clk) begin
    if (mon_en) begin
      eb = (bm ? bclk_o : bclk_in) ^ ib;
      el = (fm ? lrc_o : lrc_in) ^ ifr;
      if (!eb_p && eb) begin
        st   = (fmt >= 3) ? (el && !el_p) : (!el && el_p);
        el_p = el;
        if (st) begin
          if (jv) begin
            if (j != 64) badlen++;
            if (nf < 16) frames[nf] = cap;
            nf++;
          end
          if (nf < 16) und[nf] = underrun;
          cap = '0;
          j   = 0;
          jv  = 1;
        end
        if (jv && j < 64) cap[63 - j] = sd_o;
        if (jv) j++;
      end
      eb_p = eb;
    end
  end

  task automatic mon_rst();
    mon_en = 0; nf = 0; jv = 0; j = 0; badlen = 0; eb_p = 1;
    el_p = (fmt >= 3) ? 1'b0 : 1'b1;
    mon_en = 1;
  endtask

  // external link master for slave cases
  bit gen_en = 0;
  initial begin
    bclk_in = 1'b1;
    lrc_in  = 1'b1;
    forever begin
      @(negedge clk);
      if (gen_en) begin
        for (int s = 0; s < 64 && gen_en; s++) begin
          bclk_in = 1'b0 ^ ib;
          lrc_in  = ((fmt >= 3) ? (s == 0) : (s >= 32)) ^ ifr;
          repeat (8) @(negedge clk);
          bclk_in = 1'b1 ^ ib;
          repeat (8) @(negedge clk);
        end
      end else begin
        bclk_in = 1'b1 ^ ib;
        lrc_in  = ((fmt >= 3) ? 1'b0 : 1'b1) ^ ifr;
      end
    end
  end

  task automatic wait_frames(input int n);
    int t = 0;
    while (nf < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (nf < n) check(0, "watchdog", "frames seen", 64'(nf), 64'(n));
  endtask

  task automatic start(input logic [2:0] f, input logic [1:0] w, input logic b, input logic fr,
                       input logic m_b, input logic m_f, input logic v);
    @(negedge clk);
    rst_n = 0; gen_en = 0;
    fmt = f; wsel = w; ib = b; ifr = fr; bm = m_b; fm = m_f; sv = v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    mon_rst();
    gen_en = !m_b;
  endtask

  initial begin
    logic [63:0] e;
    logic [31:0] pl [3];
    logic [31:0] pr [3];
    int t0;

    // R12 reset state, R8 output enables
    rst_n = 0; bm = 1; fm = 0;
    repeat (3) @(negedge clk);
    check(sd_o == 0 && underrun == 0 && s_ready == 1, "R12", "sd/underrun/ready",
          {sd_o, underrun, s_ready}, 64'b001);
    check(bclk_oe == 1 && lrc_oe == 0, "R8", "output enables", {bclk_oe, lrc_oe}, 64'b10);

    // table walk
    for (int i = 0; i < 13; i++) begin
      sl = VEC[i][63:32];
      sr = VEC[i][31:0];
      start(VEC[i][72:70], VEC[i][69:68], VEC[i][67], VEC[i][66], VEC[i][65], VEC[i][64], 1'b1);
      wait_frames(3);
      e = exp_frame(fmt, wbits(wsel), sl, sr, sr);
      check(frames[2] == e, vec_tag(i), "frame bits", frames[2], e);
    end
    gen_en = 0;

    // R8 bit clock period and frame length in master mode
    sl = 32'h1234; sr = 32'h4321;
    start(3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    while (bclk_o != 1'b0) @(negedge clk);
    while (bclk_o != 1'b1) @(negedge clk);
    t0 = 0;
    @(negedge clk); t0++;
    while (bclk_o != 1'b0) begin @(negedge clk); t0++; end
    while (bclk_o != 1'b1) begin @(negedge clk); t0++; end
    check(t0 == 8, "R8", "bclk period", 64'(t0), 64'd8);
    wait_frames(3);
    check(badlen == 0, "R8", "frames not 64 slots", 64'(badlen), 64'd0);

    // R10 successive pairs through the handshake
    pl[0] = 32'h0000_A001; pr[0] = 32'h0000_B002;
    pl[1] = 32'h0000_C003; pr[1] = 32'h0000_D004;
    pl[2] = 32'h0000_E005; pr[2] = 32'h0000_F006;
    start(3'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      while (!s_ready) @(negedge clk);
      sl = pl[k]; sr = pr[k]; sv = 1;
      @(negedge clk);
      sv = 0;
      check(!s_ready, "R10", "ready after accept", 64'(s_ready), 64'd0);
    end
    wait_frames(3);
    for (int k = 0; k < 3; k++) begin
      e = exp_frame(3'd1, 16, pl[k], pr[k], '0);
      check(frames[k] == e, "R10", "pair order", frames[k], e);
    end
    check(und[0] == 0, "R11", "no underrun with data", 64'(und[0]), 64'd0);

    // R11 underrun: silence, then one pair, then silence again
    start(3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    wait_frames(2);
    check(frames[1] == 0 && und[1] == 1, "R11", "empty frame", {und[1], frames[1][62:0]}, 64'h8000_0000_0000_0000);
    sl = 32'h0000_8E71; sr = 32'h0000_1357;
    while (!s_ready) @(negedge clk);
    sv = 1;
    @(negedge clk);
    sv = 0;
    wait_frames(5);
    e = exp_frame(3'd0, 16, sl, sr, '0);
    check(frames[3] == e, "R11", "data frame", frames[3], e);
    check(und[3] == 0, "R11", "flag clears", 64'(und[3]), 64'd0);
    check(frames[4] == 0 && und[4] == 1, "R11", "flag sets again", {und[4], frames[4][62:0]}, 64'h8000_0000_0000_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual run still busy expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule